// File: doc/BRIEF.md
# NMEA navigation field extractor

This block sits beside a sentence filter that has already split an NMEA text stream into sentences and fields. For every accepted character the filter presents the byte itself, the sentence kind, the field number counted from the header, and the position of the character inside its field. From that stream the block picks out UTC time, calendar date, latitude, longitude and ground speed. Each item is kept as a row of ASCII characters; no numeric conversion is done.

Characters are written into per-item shadow storage while the sentence is being received. The visible registers change only when the filter reports the end of a sentence together with a good checksum. A corrupted or unfinished sentence therefore never disturbs the outputs. Each commit of a known sentence kind raises a one-cycle strobe that names the kind.

The byte input uses valid/ready. The block never applies back-pressure: `in_ready` is held high, and a byte counts as transferred on every clock edge where `in_valid` is high. The sentence control pins are plain single-cycle pulses.

Top module: `nmea_field_extract`

## Requirements
- R1: After reset every character of every item output is ASCII space (0x20), every item valid flag is 0 and the strobe is 0.
- R2: `in_ready` is always 1; a byte is captured only on an edge where `in_valid` is 1, and bytes presented with `in_valid` at 0 leave no trace.
- R3: Kind encoding is 0 = other, 1 = position-fix sentence (GGA), 2 = minimum-navigation sentence (RMC), 3 = course/speed sentence (VTG). In GGA field 1 and RMC field 1, characters 0-5 (hhmmss) fill time positions 0-5, character 6 (the point) is dropped, and characters 7 to 6+TFRAC fill positions 6 onward; later characters are ignored.
- R4: In GGA, field 2 characters 0-3 (degrees and minutes) become latitude positions 0-3 and the first character of field 3 (N or S) becomes position 4; e.g. 3610.5124,N gives "3610N".
- R5: In GGA, field 4 characters 0-4 become longitude positions 0-4 and the first character of field 5 (E or W) becomes position 5; e.g. 08530.4004,W gives "08530W".
- R6: In RMC, field 9 characters 0-5 (ddmmyy) become the date; RMC fields other than 1 and 9 are ignored.
- R7: In VTG, the first SPDC characters of field 7 (km/h) are stored verbatim, point included; shorter fields are padded with spaces.
- R8: Outputs change only on the clock edge that samples `sent_done` with `sent_good` high; the new values are visible in the next cycle. A sentence ending with `sent_good` low changes nothing.
- R9: `upd` is a one-hot strobe lasting one cycle after a good commit: bit 0 for GGA, bit 1 for RMC, bit 2 for VTG; kind 0 raises nothing.
- R10: An item whose digit field carried no characters in a committed sentence keeps its previous characters and clears its valid flag; a non-empty one sets the flag.
- R11: `sent_start` discards all shadow content, so characters of an abandoned sentence never reach the outputs; a good sentence of kind 0 commits nothing.
- R12: In every output the character at position 0 occupies the most significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Always 1 |
| in_char | input | 8 | ASCII character |
| in_kind | input | 2 | Sentence kind of the current sentence |
| in_field | input | FLDW | Field number, 1 = first field after the header |
| in_index | input | IDXW | Character position within the field, from 0 |
| sent_start | input | 1 | Pulse at the start of a sentence |
| sent_done | input | 1 | Pulse at the end of a sentence |
| sent_good | input | 1 | Checksum good, sampled with sent_done |
| time_chars | output | 8*(6+TFRAC) | hhmmss plus fraction digits |
| time_ok | output | 1 | Time valid |
| date_chars | output | 48 | ddmmyy |
| date_ok | output | 1 | Date valid |
| lat_chars | output | 40 | Latitude ddmm and hemisphere letter |
| lat_ok | output | 1 | Latitude valid |
| lon_chars | output | 48 | Longitude dddmm and hemisphere letter |
| lon_ok | output | 1 | Longitude valid |
| speed_chars | output | 8*SPDC | Speed in km/h, verbatim |
| speed_ok | output | 1 | Speed valid |
| upd | output | 3 | One-cycle commit strobe per kind |

## Verification
The bench builds the block with TFRAC = 1 and SPDC = 4, so that ordinary sentence text already runs past the kept fraction digit and past the speed width, making both truncation rules visible with short strings. A sweep of 48 generated position-fix sentences, every third one carrying a bad checksum, compares all outputs with values the bench derives arithmetically from the loop counter. Directed sentences cover empty fields, abandoned sentences, unknown kinds, bytes with valid low and short speed fields.

// File: rtl/nmea_fx_pkg.sv
package nmea_fx_pkg;
  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_GGA   = 2'd1,
    KIND_RMC   = 2'd2,
    KIND_VTG   = 2'd3
  } kind_e;

  localparam int N_ITEMS = 5;
  localparam int IT_TIME = 0;
  localparam int IT_DATE = 1;
  localparam int IT_LAT  = 2;
  localparam int IT_LON  = 3;
  localparam int IT_SPD  = 4;

  localparam logic [7:0] CH_BLANK = 8'h20;
endpackage

// File: rtl/nmea_fx_decode.sv
module nmea_fx_decode
  import nmea_fx_pkg::*;
#(
  parameter int IDXW  = 5,
  parameter int FLDW  = 5,
  parameter int TFRAC = 2,
  parameter int SPDC  = 5
) (
  input  kind_e              kind,
  input  logic [FLDW-1:0]    field,
  input  logic [IDXW-1:0]    idx,
  output logic [N_ITEMS-1:0] sel,
  output logic [IDXW-1:0]    pos,
  output logic               mark,
  output logic [N_ITEMS-1:0] owner
);
  localparam int FRAC_END = 7 + TFRAC;

  int f_i;
  int x_i;

  always_comb begin
    f_i  = int'(field);
    x_i  = int'(idx);
    sel  = '0;
    pos  = idx;
    mark = 1'b0;
    // time field shared by two sentence kinds
    if ((kind == KIND_GGA || kind == KIND_RMC) && f_i == 1) begin
      if (x_i < 6) begin
        sel[IT_TIME] = 1'b1;
        mark         = 1'b1;
      end else if (x_i >= 7 && x_i < FRAC_END) begin
        sel[IT_TIME] = 1'b1;
        mark         = 1'b1;
        pos          = idx - IDXW'(1);
      end
    end
    case (kind)
      KIND_GGA: begin
        if (f_i == 2 && x_i < 4) begin
          sel[IT_LAT] = 1'b1;
          mark        = 1'b1;
        end else if (f_i == 3 && x_i == 0) begin
          sel[IT_LAT] = 1'b1;
          pos         = IDXW'(4);
        end else if (f_i == 4 && x_i < 5) begin
          sel[IT_LON] = 1'b1;
          mark        = 1'b1;
        end else if (f_i == 5 && x_i == 0) begin
          sel[IT_LON] = 1'b1;
          pos         = IDXW'(5);
        end
      end
      KIND_RMC: begin
        if (f_i == 9 && x_i < 6) begin
          sel[IT_DATE] = 1'b1;
          mark         = 1'b1;
        end
      end
      KIND_VTG: begin
        if (f_i == 7 && x_i < SPDC) begin
          sel[IT_SPD] = 1'b1;
          mark        = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    owner = '0;
    case (kind)
      KIND_GGA: begin
        owner[IT_TIME] = 1'b1;
        owner[IT_LAT]  = 1'b1;
        owner[IT_LON]  = 1'b1;
      end
      KIND_RMC: begin
        owner[IT_TIME] = 1'b1;
        owner[IT_DATE] = 1'b1;
      end
      KIND_VTG: owner[IT_SPD] = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/nmea_fx_slot.sv
module nmea_fx_slot
  import nmea_fx_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int POSW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [POSW-1:0]  pos,
  input  logic             mark,
  input  logic [7:0]       ch,
  input  logic             commit,
  output logic [8*NCH-1:0] value,
  output logic             ok
);
  logic [7:0] shadow [NCH];
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NCH; p++) shadow[p] <= CH_BLANK;
      seen <= 1'b0;
    end else if (clr) begin
      for (int p = 0; p < NCH; p++) shadow[p] <= CH_BLANK;
      seen <= 1'b0;
    end else if (wr) begin
      for (int p = 0; p < NCH; p++)
        if (pos == POSW'(p)) shadow[p] <= ch;
      if (mark) seen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= {NCH{CH_BLANK}};
      ok    <= 1'b0;
    end else if (commit) begin
      ok <= seen;
      if (seen)
        for (int p = 0; p < NCH; p++) value[8*(NCH-p)-1 -: 8] <= shadow[p];
    end
  end
endmodule

// File: rtl/nmea_field_extract.sv
module nmea_field_extract
  import nmea_fx_pkg::*;
#(
  parameter int IDXW  = 5,
  parameter int FLDW  = 5,
  parameter int TFRAC = 2,
  parameter int SPDC  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_char,
  input  logic [1:0]              in_kind,
  input  logic [FLDW-1:0]         in_field,
  input  logic [IDXW-1:0]         in_index,
  input  logic                    sent_start,
  input  logic                    sent_done,
  input  logic                    sent_good,
  output logic [8*(6+TFRAC)-1:0]  time_chars,
  output logic                    time_ok,
  output logic [47:0]             date_chars,
  output logic                    date_ok,
  output logic [39:0]             lat_chars,
  output logic                    lat_ok,
  output logic [47:0]             lon_chars,
  output logic                    lon_ok,
  output logic [8*SPDC-1:0]       speed_chars,
  output logic                    speed_ok,
  output logic [2:0]              upd
);
  localparam int TCH = 6 + TFRAC;

  kind_e              kind;
  logic [N_ITEMS-1:0] sel, owner, wr, commit;
  logic [IDXW-1:0]    pos;
  logic               mark;
  logic               good_end;

  assign kind     = kind_e'(in_kind);
  assign in_ready = 1'b1;
  assign good_end = sent_done & sent_good;
  assign wr       = sel & {N_ITEMS{in_valid}};
  assign commit   = owner & {N_ITEMS{good_end}};

  nmea_fx_decode #(.IDXW(IDXW), .FLDW(FLDW), .TFRAC(TFRAC), .SPDC(SPDC)) u_dec (
    .kind(kind), .field(in_field), .idx(in_index),
    .sel(sel), .pos(pos), .mark(mark), .owner(owner)
  );

  nmea_fx_slot #(.NCH(TCH), .POSW(IDXW)) u_time (
    .clk(clk), .rst_n(rst_n), .clr(sent_start), .wr(wr[IT_TIME]), .pos(pos),
    .mark(mark), .ch(in_char), .commit(commit[IT_TIME]),
    .value(time_chars), .ok(time_ok)
  );

  nmea_fx_slot #(.NCH(6), .POSW(IDXW)) u_date (
    .clk(clk), .rst_n(rst_n), .clr(sent_start), .wr(wr[IT_DATE]), .pos(pos),
    .mark(mark), .ch(in_char), .commit(commit[IT_DATE]),
    .value(date_chars), .ok(date_ok)
  );

  nmea_fx_slot #(.NCH(5), .POSW(IDXW)) u_lat (
    .clk(clk), .rst_n(rst_n), .clr(sent_start), .wr(wr[IT_LAT]), .pos(pos),
    .mark(mark), .ch(in_char), .commit(commit[IT_LAT]),
    .value(lat_chars), .ok(lat_ok)
  );

  nmea_fx_slot #(.NCH(6), .POSW(IDXW)) u_lon (
    .clk(clk), .rst_n(rst_n), .clr(sent_start), .wr(wr[IT_LON]), .pos(pos),
    .mark(mark), .ch(in_char), .commit(commit[IT_LON]),
    .value(lon_chars), .ok(lon_ok)
  );

  nmea_fx_slot #(.NCH(SPDC), .POSW(IDXW)) u_spd (
    .clk(clk), .rst_n(rst_n), .clr(sent_start), .wr(wr[IT_SPD]), .pos(pos),
    .mark(mark), .ch(in_char), .commit(commit[IT_SPD]),
    .value(speed_chars), .ok(speed_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd <= 3'b000;
    else if (good_end)
      upd <= {kind == KIND_VTG, kind == KIND_RMC, kind == KIND_GGA};
    else upd <= 3'b000;
  end
endmodule

// File: rtl/nmea_fx_check.sv
module nmea_fx_check #(
  parameter int TFRAC = 2,
  parameter int SPDC  = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic [1:0]             in_kind,
  input logic                   sent_done,
  input logic                   sent_good,
  input logic [8*(6+TFRAC)-1:0] time_chars,
  input logic                   time_ok,
  input logic [47:0]            date_chars,
  input logic                   date_ok,
  input logic [39:0]            lat_chars,
  input logic                   lat_ok,
  input logic [47:0]            lon_chars,
  input logic                   lon_ok,
  input logic [8*SPDC-1:0]      speed_chars,
  input logic                   speed_ok,
  input logic [2:0]             upd
);
  p_ready_high_r2: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  p_hold_no_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sent_done && sent_good) |=> $stable(time_chars) && $stable(date_chars) &&
      $stable(lat_chars) && $stable(lon_chars) && $stable(speed_chars) &&
      $stable(time_ok) && $stable(date_ok) && $stable(lat_ok) &&
      $stable(lon_ok) && $stable(speed_ok));

  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(upd));

  p_strobe_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sent_done && sent_good) |=> upd == 3'b000);

  p_strobe_other_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_done && sent_good && in_kind == 2'd0) |=> upd == 3'b000);

  p_empty_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(time_ok) |-> $stable(time_chars));
endmodule

bind nmea_field_extract nmea_fx_check #(.TFRAC(TFRAC), .SPDC(SPDC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .in_kind(in_kind),
  .sent_done(sent_done), .sent_good(sent_good),
  .time_chars(time_chars), .time_ok(time_ok), .date_chars(date_chars),
  .date_ok(date_ok), .lat_chars(lat_chars), .lat_ok(lat_ok),
  .lon_chars(lon_chars), .lon_ok(lon_ok), .speed_chars(speed_chars),
  .speed_ok(speed_ok), .upd(upd)
);

// File: tb/nmea_field_extract_test.sv
`timescale 1ns/1ps
module nmea_field_extract_test;
  localparam int TFRAC = 1;
  localparam int SPDC  = 4;
  localparam int TCH   = 6 + TFRAC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_char = 8'h0;
  logic [1:0] in_kind = 2'd0;
  logic [4:0] in_field = 5'd0;
  logic [4:0] in_index = 5'd0;
  logic sent_start = 1'b0, sent_done = 1'b0, sent_good = 1'b0;
  logic [8*TCH-1:0] time_chars;
  logic [47:0] date_chars, lon_chars;
  logic [39:0] lat_chars;
  logic [8*SPDC-1:0] speed_chars;
  logic time_ok, date_ok, lat_ok, lon_ok, speed_ok;
  logic [2:0] upd;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  nmea_field_extract #(.TFRAC(TFRAC), .SPDC(SPDC)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_char(in_char), .in_kind(in_kind), .in_field(in_field), .in_index(in_index),
    .sent_start(sent_start), .sent_done(sent_done), .sent_good(sent_good),
    .time_chars(time_chars), .time_ok(time_ok), .date_chars(date_chars),
    .date_ok(date_ok), .lat_chars(lat_chars), .lat_ok(lat_ok),
    .lon_chars(lon_chars), .lon_ok(lon_ok), .speed_chars(speed_chars),
    .speed_ok(speed_ok), .upd(upd)
  );

  function automatic logic [63:0] txt(string s, int n);
    logic [63:0] r = '0;
    for (int p = 0; p < n; p++)
      r[8*(n-p)-1 -: 8] = (p < s.len()) ? s[p] : 8'h20;
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_field(int kind, int fld, string s);
    for (int i = 0; i < s.len(); i++) begin
      in_valid = 1'b1; in_char = s[i]; in_kind = 2'(kind);
      in_field = 5'(fld); in_index = 5'(i);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic start_s(int kind);
    in_kind = 2'(kind); sent_start = 1'b1;
    @(negedge clk);
    sent_start = 1'b0;
  endtask

  task automatic end_s(int kind, bit good);
    in_kind = 2'(kind); sent_done = 1'b1; sent_good = good;
    @(negedge clk);
    sent_done = 1'b0; sent_good = 1'b0;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string et, ela, elo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R2 ready
    chk("R1 time", 64'(time_chars), txt("", TCH));
    chk("R1 lat", 64'(lat_chars), txt("", 5));
    chk("R1 flags", 64'({time_ok, date_ok, lat_ok, lon_ok, speed_ok, upd}), 64'h0);
    chk("R2 ready", 64'(in_ready), 64'h1);

    // R3 R4 R5 R9 R12 full GGA sentence
    start_s(1);
    put_field(1, 1, "211701.307");
    put_field(1, 2, "3610.5124");
    put_field(1, 3, "N");
    put_field(1, 4, "08530.4004");
    put_field(1, 5, "W");
    put_field(1, 6, "1");
    end_s(1, 1);
    chk("R9 gga strobe", 64'(upd), 64'h1);
    chk("R3 R12 time", 64'(time_chars), txt("2117013", TCH));
    chk("R4 lat", 64'(lat_chars), txt("3610N", 5));
    chk("R5 lon", 64'(lon_chars), txt("08530W", 6));
    chk("R10 ok set", 64'({time_ok, lat_ok, lon_ok, date_ok}), 64'he);
    @(negedge clk);
    chk("R9 strobe one cycle", 64'(upd), 64'h0);

    // R8 bad checksum
    start_s(1);
    put_field(1, 1, "000102.0");
    put_field(1, 2, "1111.1");
    end_s(1, 0);
    chk("R8 bad strobe", 64'(upd), 64'h0);
    chk("R8 bad time", 64'(time_chars), txt("2117013", TCH));
    chk("R8 bad lat", 64'(lat_chars), txt("3610N", 5));

    // R6 RMC
    start_s(2);
    put_field(2, 1, "093005.5");
    put_field(2, 2, "A");
    put_field(2, 3, "4807.038");
    put_field(2, 9, "150113");
    end_s(2, 1);
    chk("R9 rmc strobe", 64'(upd), 64'h2);
    chk("R6 time", 64'(time_chars), txt("0930055", TCH));
    chk("R6 date", 64'(date_chars), txt("150113", 6));
    chk("R6 lat untouched", 64'(lat_chars), txt("3610N", 5));

    // R7 VTG
    start_s(3);
    put_field(3, 5, "9.9");
    put_field(3, 7, "123.45");
    end_s(3, 1);
    chk("R9 vtg strobe", 64'(upd), 64'h4);
    chk("R7 speed trunc", 64'(speed_chars), txt("123.", SPDC));
    start_s(3);
    put_field(3, 7, "7.5");
    end_s(3, 1);
    chk("R7 speed pad", 64'(speed_chars), txt("7.5", SPDC));

    // R10 empty time field in GGA
    start_s(1);
    put_field(1, 2, "4512.0");
    put_field(1, 3, "S");
    end_s(1, 1);
    chk("R10 time kept", 64'(time_chars), txt("0930055", TCH));
    chk("R10 time_ok cleared", 64'(time_ok), 64'h0);
    chk("R10 lat new", 64'({lat_chars, lat_ok}), {txt("4512S", 5), 1'b1} & 64'hFF_FFFF_FFFF_FF);
    chk("R10 lon_ok cleared", 64'({lon_chars, lon_ok}), {txt("08530W", 6), 1'b0} & 64'h01FF_FFFF_FFFF_FFFF);

    // R11 abandoned sentence, then kind 0
    start_s(1);
    put_field(1, 1, "111111.1");
    start_s(1);
    put_field(1, 2, "0101.0");
    end_s(1, 1);
    chk("R11 abandoned time", 64'({time_chars, time_ok}), {txt("0930055", TCH), 1'b0} & 64'hFFFF_FFFF_FFFF_FF);
    chk("R11 lat", 64'(lat_chars), txt("0101", 5));
    start_s(0);
    put_field(0, 1, "222222");
    end_s(0, 1);
    chk("R11 other strobe", 64'(upd), 64'h0);
    chk("R11 other time", 64'(time_chars), txt("0930055", TCH));

    // R2 bytes with valid low ignored
    start_s(1);
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b0; in_char = "9"; in_kind = 2'd1; in_field = 5'd1; in_index = 5'(i);
      @(negedge clk);
    end
    put_field(1, 1, "000000");
    end_s(1, 1);
    chk("R2 valid low ignored", 64'(time_chars), txt("000000", TCH));

    // sweep: R3 R4 R5 R8 with arithmetic expectations
    et = "000000"; ela = "0101"; elo = "08530W";
    for (int k = 0; k < 48; k++) begin
      string ts, la, lo, hl, ho;
      bit good;
      good = (k % 3) != 0;
      ts = $sformatf("%02d%02d%02d.%0d9", k % 24, (k * 7) % 60, (k * 13) % 60, k % 10);
      hl = (k % 2 == 0) ? "N" : "S";
      ho = (k % 4 < 2) ? "E" : "W";
      la = $sformatf("%02d%02d.%04d", k % 90, (k * 11) % 60, k * 3);
      lo = $sformatf("%03d%02d.%04d", (k * 37) % 180, (k * 17) % 60, k);
      start_s(1);
      put_field(1, 1, ts);
      put_field(1, 2, la);
      put_field(1, 3, hl);
      put_field(1, 4, lo);
      put_field(1, 5, ho);
      end_s(1, good);
      if (good) begin
        et  = {ts.substr(0, 5), ts.substr(7, 7)};
        ela = {la.substr(0, 3), hl};
        elo = {lo.substr(0, 4), ho};
      end
      chk("R3 R8 sweep time", 64'(time_chars), txt(et, TCH));
      chk("R4 R8 sweep lat", 64'(lat_chars), txt(ela, 5));
      chk("R5 R8 sweep lon", 64'(lon_chars), txt(elo, 6));
      chk("R9 sweep strobe", 64'(upd), good ? 64'h1 : 64'h0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule